// File: doc/BRIEF.md
# TDC Hit Buffer and Byte Link Serializer

This block sits behind the time-to-digital converter of a group of sixteen straw channels. It receives two independent streams of 24-bit time measurements, one for leading edges and one for trailing edges. Each stream can deliver a measurement on every clock cycle. Each stream is written into its own input queue. An arbiter moves whole measurements from the two queues into a single deeper output queue. A transmit state machine then emits the measurements on an 8-bit link word stream, one word per clock, with a flag that marks control words.

The link carries three data words per measurement, with the most significant byte first. When no measurement is ready, the link sends a comma control word. A comma is also forced in at regular intervals so that the receiver can keep checking link quality. A comma never splits the bytes of one measurement. For each stream, the block keeps a saturating count of the hits offered and a saturating count of the hits dropped because that stream's input queue was full. Both counters can be cleared by a synchronous input.

The transmit machine has four named states:
- `TX_COMMA` sends the comma.
- `TX_HI`, `TX_MID` and `TX_LO` send bits 23:16, 15:8 and 7:0 of the held measurement.

Its transitions are:
- From `TX_COMMA` or `TX_LO` (a word boundary), it goes to `TX_HI` and pops the output queue when a measurement is waiting and the run limit allows it. Otherwise it goes to `TX_COMMA`.
- `TX_HI` always goes to `TX_MID`, and `TX_MID` always goes to `TX_LO`.

The arbiter has two states, `ARB_LEAD` and `ARB_TRAIL`, which record the stream served last. It moves to the state of whichever stream it serves in a cycle. It holds its state when it serves neither stream.

Top module: `tdc_link_serializer`

## Requirements
- R1: Each stream accepts a measurement on every cycle in which its valid input is high and its input queue is not full, so back-to-back hits are taken with no gap.
- R2: Each measurement is sent as three consecutive link words with the flag low, in the order bits 23:16, 15:8, 7:0.
- R3: The leading-edge and trailing-edge input queues hold IN_DEPTH entries each (default 512), and the output queue holds OUT_DEPTH entries (default 2048). A full queue never accepts a write.
- R4: When both input queues hold data and the output queue has room, the arbiter alternates between the two streams, one measurement per cycle. After reset, the leading-edge stream is served first.
- R5: A comma, word value 8'hBC with the flag high, is sent whenever no measurement is ready at a word boundary. The link shows a comma directly after reset.
- R6: The link never carries more than COMMA_GAP-1 data words (default 255) in a row. Under a continuous load, the longest data run is exactly 255 words, which is 85 measurements.
- R7: A comma is never placed between the three words of one measurement.
- R8: Each stream's hit counter counts every valid hit offered. Its lost counter counts the hits that arrived while that stream's input queue was full, and those hits are discarded. Delivered hits plus lost hits equal offered hits.
- R9: The hit and lost counters are CNT_W bits wide (default 32). Each one stops at its all-ones value.
- R10: When cnt_clr is high at a clock edge, all four counters become zero, and this takes priority over a hit in the same cycle. Reset also zeroes the counters.
- R11: The measurements of one stream leave the link in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one measurement slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| cnt_clr | input | 1 | Synchronous clear of all hit and lost counters |
| lead_valid | input | 1 | A leading-edge measurement is present |
| lead_data | input | 24 | Leading-edge measurement |
| trail_valid | input | 1 | A trailing-edge measurement is present |
| trail_data | input | 24 | Trailing-edge measurement |
| link_word | output | 8 | Link word for this cycle |
| link_k | output | 1 | High for a control (comma) word, low for data |
| lead_hits | output | CNT_W | Leading-edge hits offered |
| lead_lost | output | CNT_W | Leading-edge hits dropped |
| trail_hits | output | CNT_W | Trailing-edge hits offered |
| trail_lost | output | CNT_W | Trailing-edge hits dropped |

## Verification
The in-line properties watch, on every cycle, the following:
- A full queue is never written and an empty queue is never read.
- The `TX_HI`, `TX_MID`, `TX_LO` sequence is never broken.
- The data-run counter stays within its limit, and an empty queue at a boundary leads to a comma.
- The arbiter hands over to the other stream when both are waiting.
- The lost count never exceeds the hit count, and the counters saturate and clear correctly.

Other behaviour can only be shown by the directed scenarios:
- Exact byte order, and the data contents and ordering that come out of the link.
- Strict alternation over a simultaneous burst.
- The balance of delivered plus lost against offered under overflow.
- A 255-word maximum run under a saturated link.
- Counter stop values after tens of thousands of hits.

// File: rtl/tdcl_pkg.sv
package tdcl_pkg;

    localparam int MEAS_W         = 24;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_MEAS = MEAS_W / BYTE_W;

    typedef enum logic [1:0] {
        TX_COMMA,
        TX_HI,
        TX_MID,
        TX_LO
    } tx_state_e;

    typedef enum logic {
        ARB_LEAD,
        ARB_TRAIL
    } arb_side_e;

endpackage

// File: rtl/tdcl_fifo.sv
module tdcl_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW:0]   level;
    logic          push;
    logic          pop;

    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (level == '0);
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) begin
                wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            end
            if (pop) begin
                rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            end
            if (push && !pop) begin
                level <= level + (AW+1)'(1);
            end else if (pop && !push) begin
                level <= level - (AW+1)'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= wr_data;
        end
    end

    // R3: a full queue stays full unless it is read
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_en) |=> full);

    // R3: an empty queue stays empty unless it is written
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (empty && !wr_en) |=> empty);

endmodule

// File: rtl/tdcl_hit_cnt.sv
module tdcl_hit_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             hit,
    input  logic             drop,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] lost
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            total <= '0;
            lost  <= '0;
        end else begin
            if (hit && (total != CNT_MAX)) begin
                total <= total + CNT_W'(1);
            end
            if (drop && (lost != CNT_MAX)) begin
                lost <= lost + CNT_W'(1);
            end
        end
    end

    // R8: dropped hits are a subset of offered hits
    p_lost_le_total_r8: assert property (@(posedge clk) disable iff (rst)
        lost <= total);

    // R9: a saturated counter holds its value
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (total == CNT_MAX && !clr) |=> (total == CNT_MAX));

    // R10: clear zeroes both counters on the next cycle
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (total == '0 && lost == '0));

endmodule

// File: rtl/tdcl_merge.sv
module tdcl_merge
    import tdcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lead_empty,
    input  logic [MEAS_W-1:0] lead_data,
    input  logic              trail_empty,
    input  logic [MEAS_W-1:0] trail_data,
    input  logic              out_full,
    output logic              lead_pop,
    output logic              trail_pop,
    output logic              out_push,
    output logic [MEAS_W-1:0] out_data
);
    arb_side_e last_q;
    arb_side_e last_d;
    logic      lead_ok;
    logic      trail_ok;
    logic      pick_lead;
    logic      pick_trail;

    always_comb begin
        lead_ok    = !lead_empty && !out_full;
        trail_ok   = !trail_empty && !out_full;
        pick_lead  = 1'b0;
        pick_trail = 1'b0;
        last_d     = last_q;
        unique case (last_q)
            ARB_TRAIL: begin
                pick_lead  = lead_ok;
                pick_trail = trail_ok && !lead_ok;
            end
            ARB_LEAD: begin
                pick_trail = trail_ok;
                pick_lead  = lead_ok && !trail_ok;
            end
        endcase
        if (pick_lead) begin
            last_d = ARB_LEAD;
        end else if (pick_trail) begin
            last_d = ARB_TRAIL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= ARB_TRAIL;
        end else begin
            last_q <= last_d;
        end
    end

    always_comb begin
        lead_pop  = pick_lead;
        trail_pop = pick_trail;
        out_push  = pick_lead || pick_trail;
        out_data  = pick_lead ? lead_data : trail_data;
    end

    // R4: after a leading-edge move, a waiting trailing edge is served next
    p_rr_to_trail_r4: assert property (@(posedge clk) disable iff (rst)
        (lead_pop && !trail_empty && !trail_pop) |=> (trail_empty || out_full || trail_pop));

    // R4: after a trailing-edge move, a waiting leading edge is served next
    p_rr_to_lead_r4: assert property (@(posedge clk) disable iff (rst)
        (trail_pop && !lead_empty && !lead_pop) |=> (lead_empty || out_full || lead_pop));

endmodule

// File: rtl/tdcl_link_tx.sv
module tdcl_link_tx
    import tdcl_pkg::*;
#(
    parameter int                COMMA_GAP  = 256,
    parameter logic [BYTE_W-1:0] COMMA_CODE = 8'hBC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [MEAS_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic [BYTE_W-1:0] link_word,
    output logic              link_k
);
    localparam int MAX_RUN = COMMA_GAP - 1;
    localparam int RUN_W   = $clog2(COMMA_GAP + 1);

    tx_state_e         state;
    tx_state_e         nxt;
    logic [MEAS_W-1:0] hold;
    logic [RUN_W-1:0]  run;
    logic              room;

    always_comb begin
        room = (int'(run) + BYTES_PER_MEAS) <= MAX_RUN;
        nxt  = TX_COMMA;
        unique case (state)
            TX_COMMA, TX_LO: nxt = (!fifo_empty && room) ? TX_HI : TX_COMMA;
            TX_HI:           nxt = TX_MID;
            TX_MID:          nxt = TX_LO;
        endcase
        fifo_pop = (state == TX_COMMA || state == TX_LO) && (nxt == TX_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_COMMA;
            run   <= '0;
            hold  <= '0;
        end else begin
            state <= nxt;
            if (fifo_pop) begin
                hold <= fifo_data;
            end
            if (nxt == TX_COMMA) begin
                run <= '0;
            end else begin
                run <= run + RUN_W'(1);
            end
        end
    end

    always_comb begin
        link_word = COMMA_CODE;
        link_k    = 1'b1;
        unique case (state)
            TX_COMMA: begin
                link_word = COMMA_CODE;
                link_k    = 1'b1;
            end
            TX_HI: begin
                link_word = hold[23:16];
                link_k    = 1'b0;
            end
            TX_MID: begin
                link_word = hold[15:8];
                link_k    = 1'b0;
            end
            TX_LO: begin
                link_word = hold[7:0];
                link_k    = 1'b0;
            end
        endcase
    end

    // R7: the three bytes of a measurement are never split
    p_hi_then_mid_r7: assert property (@(posedge clk) disable iff (rst)
        (state == TX_HI) |=> (state == TX_MID));
    p_mid_then_lo_r7: assert property (@(posedge clk) disable iff (rst)
        (state == TX_MID) |=> (state == TX_LO));

    // R6: the data run never exceeds the comma interval
    p_run_limit_r6: assert property (@(posedge clk) disable iff (rst)
        int'(run) <= MAX_RUN);

    // R5: nothing queued at a boundary means a comma follows
    p_idle_comma_r5: assert property (@(posedge clk) disable iff (rst)
        ((state == TX_COMMA || state == TX_LO) && fifo_empty) |=> (state == TX_COMMA));

endmodule

// File: rtl/tdc_link_serializer.sv
module tdc_link_serializer
    import tdcl_pkg::*;
#(
    parameter int                IN_DEPTH   = 512,
    parameter int                OUT_DEPTH  = 2048,
    parameter int                CNT_W      = 32,
    parameter int                COMMA_GAP  = 256,
    parameter logic [BYTE_W-1:0] COMMA_CODE = 8'hBC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clr,
    input  logic              lead_valid,
    input  logic [MEAS_W-1:0] lead_data,
    input  logic              trail_valid,
    input  logic [MEAS_W-1:0] trail_data,
    output logic [BYTE_W-1:0] link_word,
    output logic              link_k,
    output logic [CNT_W-1:0]  lead_hits,
    output logic [CNT_W-1:0]  lead_lost,
    output logic [CNT_W-1:0]  trail_hits,
    output logic [CNT_W-1:0]  trail_lost
);
    localparam int N_EDGE = 2;

    logic [N_EDGE-1:0] e_vld;
    logic [MEAS_W-1:0] e_din  [N_EDGE];
    logic [MEAS_W-1:0] e_dout [N_EDGE];
    logic [N_EDGE-1:0] e_full;
    logic [N_EDGE-1:0] e_empty;
    logic [N_EDGE-1:0] e_pop;
    logic [CNT_W-1:0]  e_hits [N_EDGE];
    logic [CNT_W-1:0]  e_lost [N_EDGE];

    logic              o_push;
    logic [MEAS_W-1:0] o_din;
    logic [MEAS_W-1:0] o_dout;
    logic              o_full;
    logic              o_empty;
    logic              o_pop;

    assign e_vld    = {trail_valid, lead_valid};
    assign e_din[0] = lead_data;
    assign e_din[1] = trail_data;

    for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
        tdcl_fifo #(
            .W     (MEAS_W),
            .DEPTH (IN_DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (e_vld[e]),
            .wr_data (e_din[e]),
            .rd_en   (e_pop[e]),
            .rd_data (e_dout[e]),
            .full    (e_full[e]),
            .empty   (e_empty[e])
        );

        tdcl_hit_cnt #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (cnt_clr),
            .hit   (e_vld[e]),
            .drop  (e_vld[e] && e_full[e]),
            .total (e_hits[e]),
            .lost  (e_lost[e])
        );
    end

    tdcl_merge u_merge (
        .clk         (clk),
        .rst         (rst),
        .lead_empty  (e_empty[0]),
        .lead_data   (e_dout[0]),
        .trail_empty (e_empty[1]),
        .trail_data  (e_dout[1]),
        .out_full    (o_full),
        .lead_pop    (e_pop[0]),
        .trail_pop   (e_pop[1]),
        .out_push    (o_push),
        .out_data    (o_din)
    );

    tdcl_fifo #(
        .W     (MEAS_W),
        .DEPTH (OUT_DEPTH)
    ) u_out_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (o_push),
        .wr_data (o_din),
        .rd_en   (o_pop),
        .rd_data (o_dout),
        .full    (o_full),
        .empty   (o_empty)
    );

    tdcl_link_tx #(
        .COMMA_GAP  (COMMA_GAP),
        .COMMA_CODE (COMMA_CODE)
    ) u_tx (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (o_empty),
        .fifo_data  (o_dout),
        .fifo_pop   (o_pop),
        .link_word  (link_word),
        .link_k     (link_k)
    );

    assign lead_hits  = e_hits[0];
    assign lead_lost  = e_lost[0];
    assign trail_hits = e_hits[1];
    assign trail_lost = e_lost[1];

    // R1: a hit offered to a non-full queue is never counted as lost
    p_no_dead_time_r1: assert property (@(posedge clk) disable iff (rst || cnt_clr)
        (lead_valid && !e_full[0]) |=> $stable(lead_lost));

endmodule

// File: tb/test_tdc_link_serializer.sv
`timescale 1ns/1ps
module test_tdc_link_serializer;
    localparam realtime CLK_PERIOD = 6.25;
    localparam int      CNT_W      = 16;
    localparam int      WATCHDOG   = 190000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cnt_clr = 1'b0;
    logic             lead_valid = 1'b0;
    logic [23:0]      lead_data = '0;
    logic             trail_valid = 1'b0;
    logic [23:0]      trail_data = '0;
    logic [7:0]       link_word;
    logic             link_k;
    logic [CNT_W-1:0] lead_hits, lead_lost, trail_hits, trail_lost;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // link monitor state
    int          phase = 0;
    int          run = 0;
    int          max_run = 0;
    int          comma_cnt = 0;
    int          viol_r5 = 0;
    int          viol_r6 = 0;
    int          viol_r7 = 0;
    logic [23:0] asm_w = '0;
    logic [23:0] rx_q [$];

    tdc_link_serializer #(.CNT_W(CNT_W)) i_tdc_link_serializer (
        .clk        (clk),
        .rst        (rst),
        .cnt_clr    (cnt_clr),
        .lead_valid (lead_valid),
        .lead_data  (lead_data),
        .trail_valid(trail_valid),
        .trail_data (trail_data),
        .link_word  (link_word),
        .link_k     (link_k),
        .lead_hits  (lead_hits),
        .lead_lost  (lead_lost),
        .trail_hits (trail_hits),
        .trail_lost (trail_lost)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst) begin
            phase = 0;
            run   = 0;
        end else if (link_k) begin
            if (link_word != 8'hBC) viol_r5++;
            if (phase != 0) viol_r7++;
            run = 0;
            comma_cnt++;
        end else begin
            run++;
            if (run > 255) viol_r6++;
            if (run > max_run) max_run = run;
            asm_w = {asm_w[15:0], link_word};
            phase++;
            if (phase == 3) begin
                rx_q.push_back(asm_w);
                phase = 0;
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        lead_valid = 1'b0;
        trail_valid = 1'b0;
        cnt_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rx_q.delete();
        max_run = 0;
    endtask

    task automatic drain();
        int quiet = 0;
        while (quiet < 12) begin
            @(negedge clk);
            if (link_k) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R5", link_k, 1, "link_k after reset");
        chk("R5", link_word, 8'hBC, "comma code after reset");
        chk("R8", lead_hits + lead_lost, 0, "lead counters after reset");
        chk("R8", trail_hits + trail_lost, 0, "trail counters after reset");
    endtask

    task automatic t_idle();
        int c0;
        do_reset();
        c0 = comma_cnt;
        repeat (300) @(negedge clk);
        chk("R5", comma_cnt - c0, 300, "commas in idle window");
        chk("R5", rx_q.size(), 0, "data words in idle window");
    endtask

    task automatic t_single();
        do_reset();
        @(negedge clk);
        lead_valid = 1'b1;
        lead_data  = 24'hA5C3E1;
        @(negedge clk);
        lead_valid = 1'b0;
        chk("R8", lead_hits, 1, "lead hits single");
        drain();
        chk("R2", rx_q.size(), 1, "measurements single");
        if (rx_q.size() > 0) chk("R2", rx_q[0], 24'hA5C3E1, "bytes MSB first");
    endtask

    task automatic t_burst();
        int bad = 0;
        do_reset();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            lead_valid  = 1'b1;
            lead_data   = 24'h100000 + 24'(i);
            trail_valid = 1'b1;
            trail_data  = 24'h200000 + 24'(i);
        end
        @(negedge clk);
        lead_valid  = 1'b0;
        trail_valid = 1'b0;
        chk("R1", lead_hits, 20, "lead back-to-back hits");
        chk("R1", lead_lost + trail_lost, 0, "no loss in burst");
        drain();
        chk("R4", rx_q.size(), 40, "burst measurements");
        for (int i = 0; i < 20 && 2*i+1 < rx_q.size(); i++) begin
            if (rx_q[2*i]   != 24'h100000 + 24'(i)) bad++;
            if (rx_q[2*i+1] != 24'h200000 + 24'(i)) bad++;
        end
        chk("R4", bad, 0, "alternation and R11 order mismatches");
    endtask

    task automatic t_overflow();
        int bad = 0;
        do_reset();
        for (int i = 0; i < 4500; i++) begin
            @(negedge clk);
            lead_valid = 1'b1;
            lead_data  = 24'(i);
        end
        @(negedge clk);
        lead_valid = 1'b0;
        chk("R8", lead_hits, 4500, "lead offered under overflow");
        chk("R3", lead_lost > 0, 1, "losses once queues full");
        chk("R8", trail_hits, 0, "trail untouched");
        drain();
        chk("R8", rx_q.size() + lead_lost, 4500, "delivered plus lost");
        chk("R6", max_run, 255, "longest data run under load");
        if (rx_q.size() > 0 && rx_q[0] != 0) bad++;
        for (int i = 1; i < rx_q.size(); i++) begin
            if (rx_q[i] <= rx_q[i-1]) bad++;
        end
        chk("R11", bad, 0, "order violations");
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 65540; i++) begin
            @(negedge clk);
            trail_valid = 1'b1;
            trail_data  = 24'(i);
        end
        @(negedge clk);
        trail_valid = 1'b0;
        chk("R9", trail_hits, 65535, "trail hits saturate");
        chk("R9", trail_lost < trail_hits, 1, "lost below hits");
        chk("R9", lead_hits, 0, "lead hits idle");
        do_reset();
    endtask

    task automatic t_clear();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            lead_valid  = 1'b1;
            lead_data   = 24'h0F0F00 + 24'(i);
            trail_valid = (i < 3);
            trail_data  = 24'h3C3C00 + 24'(i);
        end
        @(negedge clk);
        lead_valid  = 1'b0;
        trail_valid = 1'b0;
        chk("R8", lead_hits, 5, "lead before clear");
        chk("R8", trail_hits, 3, "trail before clear");
        lead_valid = 1'b1;
        cnt_clr    = 1'b1;
        @(negedge clk);
        lead_valid = 1'b0;
        cnt_clr    = 1'b0;
        chk("R10", lead_hits, 0, "lead cleared despite hit");
        chk("R10", trail_hits, 0, "trail cleared");
        lead_valid = 1'b1;
        @(negedge clk);
        lead_valid = 1'b0;
        chk("R10", lead_hits, 1, "counting resumes after clear");
        drain();
    endtask

    initial begin
        t_reset();
        t_idle();
        t_single();
        t_burst();
        t_overflow();
        t_clear();
        t_saturate();
        chk("R5", viol_r5, 0, "bad control words");
        chk("R6", viol_r6, 0, "runs above 255");
        chk("R7", viol_r7, 0, "commas inside a measurement");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d cycles", WATCHDOG, 0);
            summary();
            $finish;
        end
    end

endmodule